// File: doc/BRIEF.md
# Keyed Watchdog Timer

A memory-mapped watchdog with a 32-bit register port. A down-counter, loaded from a reload register, counts either on every clock or on a 1 MHz tick strobe. Software keeps the system alive by writing a fixed key to a restart register. That write is the only thing that reloads the counter, and any other value written there is dropped. When the count runs out, the block records the event in a status register. It can then issue a one-cycle reset request that carries a reset scope, pulse an external-reset line, and record that the next boot should come from the secondary image.

A pre-timeout threshold sits in the upper bits of the control word. When the running count falls to or below it, a level-sensitive early-warning interrupt rises and stays high until software writes the clear register. That clear write also wipes the expiry and boot-select status.

Top module: `wdg_timer`

## Requirements
- R1: After reset the count reads 0, the control word reads 0, status reads 0, the reload register reads RELOAD_INIT, and irq_o, rst_req_o, ext_rst_o and rst_scope_o are all 0.
- R2: A write of exactly 0x0000_4755 to offset 0x08 loads the count from the reload register and arms the counter. A write of any other value there leaves the count unchanged.
- R3: While armed with control bit 0 set, the count drops by one per step. With control bit 4 clear a step is every clock; with bit 4 set a step is a clock with tick_1m high.
- R4: With control bit 0 clear the count holds. A write to the control register never reloads the count.
- R5: On the step where the count is 1 or 0, it becomes 0 and the counter disarms. Status bit 0 is set, and the count stays 0 until the next restart key, whatever the control bits.
- R6: On expiry, if control bit 1 is set, rst_req_o is high for exactly one cycle with rst_scope_o equal to control bits 6:5 (0 SoC, 1 full chip, 2 CPU only); with bit 1 clear there is no request. ext_rst_o pulses on expiry when control bit 3 is set.
- R7: With control bits 0 and 2 set and the counter armed, once the count is at or below the threshold (control bits 31:THR_LSB shifted left by THR_LSB), status bit 2 is set. irq_o follows it and stays high until cleared.
- R8: An expiry with control bit 7 set also sets status bit 1.
- R9: Writing offset 0x14 with bit 0 set clears status bits 2:0 and irq_o; a write there with bit 0 clear changes nothing.
- R10: Reads return the count at 0x00, reload at 0x04, control at 0x0C and status at 0x10, and 0 at 0x08 and 0x14. Read data appears on the clock after the read strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_1m | input | 1 | 1 MHz step strobe, used when control bit 4 is set |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | ADDR_W | Byte address, word aligned |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid the cycle after bus_rd |
| irq_o | output | 1 | Pre-timeout interrupt, level |
| rst_req_o | output | 1 | One-cycle reset request on expiry |
| rst_scope_o | output | 2 | Reset scope carried with the request |
| ext_rst_o | output | 1 | One-cycle external reset pulse on expiry |

## Verification
The bench builds the block with THR_LSB set to 8, the lowest value the parameter checks accept, and RELOAD_INIT set to 40. The counter stays 32 bits wide. With a threshold step of 256, the early-warning interrupt can be reached and crossed from a reload of 300 within a few dozen clocks. The small reset reload value makes the reset contents easy to recognise. Counting in the every-clock mode lets expiry, the halt after expiry and the reset scope be checked in short runs, while the tick mode is driven by hand one strobe at a time.

// File: rtl/wdg_pkg.sv
package wdg_pkg;

   localparam int unsigned IDX_COUNT  = 0;
   localparam int unsigned IDX_RELOAD = 1;
   localparam int unsigned IDX_KICK   = 2;
   localparam int unsigned IDX_CTRL   = 3;
   localparam int unsigned IDX_STAT   = 4;
   localparam int unsigned IDX_CLEAR  = 5;

   localparam int unsigned CB_RUN   = 0;
   localparam int unsigned CB_RST   = 1;
   localparam int unsigned CB_IRQ   = 2;
   localparam int unsigned CB_EXT   = 3;
   localparam int unsigned CB_TICK  = 4;
   localparam int unsigned CB_SCOPE = 5;
   localparam int unsigned CB_BOOT  = 7;

   localparam int unsigned SB_EXP  = 0;
   localparam int unsigned SB_BOOT = 1;
   localparam int unsigned SB_PRE  = 2;

   typedef enum logic [1:0] {
      SCOPE_SOC  = 2'd0,
      SCOPE_CHIP = 2'd1,
      SCOPE_CPU  = 2'd2,
      SCOPE_RSVD = 2'd3
   } scope_e;

   typedef struct packed {
      logic   boot_en;
      scope_e scope;
      logic   tick_sel;
      logic   ext_en;
      logic   irq_en;
      logic   rst_en;
      logic   run;
   } ctl_t;

endpackage

// File: rtl/wdg_regs.sv
module wdg_regs
   import wdg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned THR_LSB     = 10,
   parameter int unsigned KICK_KEY    = 'h4755,
   parameter int unsigned RELOAD_INIT = 'h0F00_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic              rd,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [CNT_W-1:0]  cnt,
   input  logic [2:0]        stat,
   output ctl_t              ctl,
   output logic [DATA_W-1:0] thr,
   output logic [CNT_W-1:0]  reload,
   output logic              kick,
   output logic              clr,
   output logic [DATA_W-1:0] rdata
);
   localparam int unsigned IDX_W = ADDR_W - 2;

   logic [DATA_W-1:0] ctrl_q;
   logic [IDX_W-1:0]  idx;
   logic              aligned;
   logic              wr_ok;

   assign idx     = addr[ADDR_W-1:2];
   assign aligned = (addr[1:0] == 2'b00);
   assign wr_ok   = wr && aligned;

   assign kick = wr_ok && (idx == IDX_W'(IDX_KICK)) && (wdata == DATA_W'(KICK_KEY));
   assign clr  = wr_ok && (idx == IDX_W'(IDX_CLEAR)) && wdata[0];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         ctrl_q <= '0;
         reload <= CNT_W'(RELOAD_INIT);
      end else if (wr_ok) begin
         if (idx == IDX_W'(IDX_CTRL))   ctrl_q <= wdata;
         if (idx == IDX_W'(IDX_RELOAD)) reload <= wdata[CNT_W-1:0];
      end
   end

   assign ctl = ctl_t'(ctrl_q[7:0]);
   assign thr = {ctrl_q[DATA_W-1:THR_LSB], {THR_LSB{1'b0}}};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rdata <= '0;
      end else if (rd) begin
         rdata <= '0;
         if (aligned) begin
            case (idx)
               IDX_W'(IDX_COUNT):  rdata <= DATA_W'(cnt);
               IDX_W'(IDX_RELOAD): rdata <= DATA_W'(reload);
               IDX_W'(IDX_CTRL):   rdata <= ctrl_q;
               IDX_W'(IDX_STAT):   rdata <= DATA_W'(stat);
               default:            rdata <= '0;
            endcase
         end
      end
   end

   a_r4_ctrl_write_keeps_reload: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_ok && idx != IDX_W'(IDX_RELOAD)) |=> $stable(reload));

endmodule

// File: rtl/wdg_counter.sv
module wdg_counter #(
   parameter int unsigned CNT_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             kick,
   input  logic [CNT_W-1:0] reload,
   input  logic             run_en,
   input  logic             tick_sel,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt,
   output logic             live,
   output logic             expire
);
   logic step;

   assign step = tick_sel ? tick : 1'b1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt    <= '0;
         live   <= 1'b0;
         expire <= 1'b0;
      end else if (kick) begin
         cnt    <= reload;
         live   <= 1'b1;
         expire <= 1'b0;
      end else begin
         expire <= 1'b0;
         if (live && run_en && step) begin
            if (cnt <= CNT_W'(1)) begin
               cnt    <= '0;
               live   <= 1'b0;
               expire <= 1'b1;
            end else begin
               cnt <= cnt - CNT_W'(1);
            end
         end
      end
   end

   a_r2_kick_loads: assert property (@(posedge clk) disable iff (!rst_n)
      kick |=> (cnt == $past(reload)) && live);
   a_r4_frozen_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (!run_en && !kick) |=> $stable(cnt));
   a_r5_idle_after_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (!live && !kick) |=> $stable(cnt) && !live);
   a_r5_expire_at_zero: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (cnt == '0) && !live);

endmodule

// File: rtl/wdg_status.sv
module wdg_status (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       expire,
   input  logic       boot_en,
   input  logic       pre_hit,
   input  logic       clr,
   output logic [2:0] stat
);
   import wdg_pkg::*;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         stat <= '0;
      end else begin
         stat[SB_EXP]  <= expire | (stat[SB_EXP] & ~clr);
         stat[SB_BOOT] <= (expire & boot_en) | (stat[SB_BOOT] & ~clr);
         stat[SB_PRE]  <= pre_hit | (stat[SB_PRE] & ~clr);
      end
   end

   a_r7_irq_level: assert property (@(posedge clk) disable iff (!rst_n)
      (stat[SB_PRE] && !clr) |=> stat[SB_PRE]);
   a_r9_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (clr && !expire && !pre_hit) |=> (stat == 3'b000));
   a_r8_boot_on_expiry: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && boot_en) |=> stat[SB_BOOT] && stat[SB_EXP]);

endmodule

// File: rtl/wdg_timer.sv
module wdg_timer
   import wdg_pkg::*;
#(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned THR_LSB     = 10,
   parameter int unsigned KICK_KEY    = 'h4755,
   parameter int unsigned RELOAD_INIT = 'h0F00_0000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_1m,
   input  logic              bus_wr,
   input  logic              bus_rd,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   output logic              irq_o,
   output logic              rst_req_o,
   output logic [1:0]        rst_scope_o,
   output logic              ext_rst_o
);
   generate
      if (ADDR_W < 5) begin : g_bad_addr
         $error("ADDR_W must cover six word registers");
      end
      if (CNT_W > DATA_W || CNT_W < 2) begin : g_bad_cnt
         $error("CNT_W must lie in 2..DATA_W");
      end
      if (THR_LSB < 8 || THR_LSB >= DATA_W) begin : g_bad_thr
         $error("THR_LSB must sit above the control byte and below DATA_W");
      end
   endgenerate

   ctl_t              ctl;
   logic [DATA_W-1:0] thr;
   logic [CNT_W-1:0]  reload;
   logic [CNT_W-1:0]  cnt;
   logic              kick;
   logic              clr;
   logic              live;
   logic              expire;
   logic              pre_hit;
   logic [2:0]        stat;

   wdg_regs #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .THR_LSB(THR_LSB),
      .KICK_KEY(KICK_KEY), .RELOAD_INIT(RELOAD_INIT)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(bus_wr), .rd(bus_rd), .addr(bus_addr),
      .wdata(bus_wdata), .cnt(cnt), .stat(stat), .ctl(ctl), .thr(thr),
      .reload(reload), .kick(kick), .clr(clr), .rdata(bus_rdata)
   );

   wdg_counter #(.CNT_W(CNT_W)) u_cnt (
      .clk(clk), .rst_n(rst_n), .kick(kick), .reload(reload), .run_en(ctl.run),
      .tick_sel(ctl.tick_sel), .tick(tick_1m), .cnt(cnt), .live(live),
      .expire(expire)
   );

   assign pre_hit = live && ctl.run && ctl.irq_en && (DATA_W'(cnt) <= thr);

   wdg_status u_stat (
      .clk(clk), .rst_n(rst_n), .expire(expire), .boot_en(ctl.boot_en),
      .pre_hit(pre_hit), .clr(clr), .stat(stat)
   );

   assign irq_o       = stat[SB_PRE];
   assign rst_req_o   = expire & ctl.rst_en;
   assign ext_rst_o   = expire & ctl.ext_en;
   assign rst_scope_o = ctl.scope;

   a_r6_req_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> !rst_req_o);
   a_r5_expiry_logged: assert property (@(posedge clk) disable iff (!rst_n)
      rst_req_o |=> stat[SB_EXP]);

endmodule

// File: tb/tb_wdg_timer.sv
`timescale 1ns/1ps
module tb_wdg_timer;
   localparam int unsigned THR_LSB = 8;
   localparam int unsigned RINIT   = 40;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tick_1m = 1'b0;
   logic        bus_wr = 1'b0;
   logic        bus_rd = 1'b0;
   logic [4:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        irq_o, rst_req_o, ext_rst_o;
   logic [1:0]  rst_scope_o;

   int nchk = 0;
   int nbad = 0;
   int req_n = 0;
   int ext_n = 0;
   logic [1:0] last_scope = '0;

   always #2 clk = ~clk;

   wdg_timer #(.THR_LSB(THR_LSB), .RELOAD_INIT(RINIT)) dut (
      .clk(clk), .rst_n(rst_n), .tick_1m(tick_1m), .bus_wr(bus_wr),
      .bus_rd(bus_rd), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
      .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o),
      .rst_scope_o(rst_scope_o), .ext_rst_o(ext_rst_o)
   );

   always @(negedge clk) begin
      if (rst_n) begin
         if (rst_req_o) begin
            req_n++;
            last_scope = rst_scope_o;
         end
         if (ext_rst_o) ext_n++;
      end
   end

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nbad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic wr(input logic [4:0] a, input logic [31:0] d);
      bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_wr = 1'b0;
   endtask

   task automatic rd(input logic [4:0] a, output logic [31:0] d);
      bus_rd = 1'b1; bus_addr = a;
      @(negedge clk);
      bus_rd = 1'b0;
      d = bus_rdata;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   // reload, steps, expected count
   localparam logic [95:0] VEC [6] = '{
      {32'd100, 32'd1, 32'd99},
      {32'd100, 32'd7, 32'd93},
      {32'd3,   32'd2, 32'd1},
      {32'd2,   32'd5, 32'd0},
      {32'd1,   32'd1, 32'd0},
      {32'd0,   32'd3, 32'd0}
   };

   initial begin
      repeat (200000) @(posedge clk);
      nchk++; nbad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end

   initial begin
      logic [31:0] d;
      int r0, e0;
      idle(3);
      rst_n = 1'b1;
      idle(1);

      // R1 reset state
      chk("R1 irq", 32'(irq_o), 0);
      chk("R1 req", 32'(rst_req_o), 0);
      chk("R1 ext", 32'(ext_rst_o), 0);
      chk("R1 scope", 32'(rst_scope_o), 0);
      rd(5'h00, d); chk("R1 count", d, 0);
      rd(5'h04, d); chk("R1 reload", d, RINIT);
      rd(5'h0C, d); chk("R1 ctrl", d, 0);
      rd(5'h10, d); chk("R1 status", d, 0);

      // R2 restart key
      wr(5'h04, 32'd50); wr(5'h08, 32'h4755);
      rd(5'h00, d); chk("R2 key loads", d, 50);
      wr(5'h04, 32'd77);
      wr(5'h08, 32'h4756);
      rd(5'h00, d); chk("R2 wrong key", d, 50);
      wr(5'h08, 32'h0001_4755);
      rd(5'h00, d); chk("R2 key upper bits", d, 50);
      wr(5'h08, 32'h4755);
      rd(5'h00, d); chk("R2 key reload", d, 77);

      // R10 read map
      rd(5'h04, d); chk("R10 reload read", d, 77);
      rd(5'h08, d); chk("R10 restart reads 0", d, 0);
      rd(5'h14, d); chk("R10 clear reads 0", d, 0);

      // R4 control write does not reload, disabled count holds
      wr(5'h0C, 32'h10);
      rd(5'h00, d); chk("R4 ctrl write", d, 77);
      idle(5);
      rd(5'h00, d); chk("R4 frozen", d, 77);
      rd(5'h0C, d); chk("R10 ctrl read", d, 32'h10);

      // R3/R5 vector table, every-clock mode
      foreach (VEC[i]) begin
         wr(5'h0C, 0);
         wr(5'h04, VEC[i][95:64]);
         wr(5'h08, 32'h4755);
         wr(5'h0C, 32'h1);
         if (VEC[i][63:32] > 1) idle(int'(VEC[i][63:32]) - 1);
         wr(5'h0C, 0);
         rd(5'h00, d);
         chk($sformatf("R3 vec%0d", i), d, VEC[i][31:0]);
      end
      wr(5'h14, 32'h1);

      // R3 tick mode
      wr(5'h0C, 0); wr(5'h04, 32'd30); wr(5'h08, 32'h4755);
      wr(5'h0C, 32'h11);
      idle(10);
      rd(5'h00, d); chk("R3 no tick no step", d, 30);
      tick_1m = 1'b1; idle(3); tick_1m = 1'b0;
      rd(5'h00, d); chk("R3 three ticks", d, 27);
      wr(5'h0C, 0);

      // R5/R6/R8 expiry with request, scope CPU, ext, boot
      wr(5'h04, 32'd5); wr(5'h08, 32'h4755); wr(5'h14, 32'h1);
      r0 = req_n; e0 = ext_n;
      wr(5'h0C, 32'hCB);
      idle(20);
      chk("R6 one request", 32'(req_n - r0), 1);
      chk("R6 scope cpu", 32'(last_scope), 2);
      chk("R6 ext pulse", 32'(ext_n - e0), 1);
      rd(5'h00, d); chk("R5 count zero", d, 0);
      rd(5'h10, d); chk("R8 status exp+boot", d, 32'h3);
      wr(5'h0C, 0); wr(5'h0C, 32'hCB); idle(5);
      rd(5'h00, d); chk("R5 halted", d, 0);
      chk("R5 no new request", 32'(req_n - r0), 1);
      wr(5'h0C, 0); wr(5'h08, 32'h4755);
      rd(5'h00, d); chk("R5 restart resumes", d, 5);

      // R6 no request with bit1 clear, R8 no boot with bit7 clear
      wr(5'h04, 32'd3); wr(5'h08, 32'h4755); wr(5'h14, 32'h1);
      r0 = req_n; e0 = ext_n;
      wr(5'h0C, 32'h21);
      idle(10);
      chk("R6 no request", 32'(req_n - r0), 0);
      chk("R6 no ext", 32'(ext_n - e0), 0);
      rd(5'h10, d); chk("R8 exp only", d, 32'h1);

      // R6 scope SoC
      wr(5'h0C, 0); wr(5'h04, 32'd2); wr(5'h08, 32'h4755); wr(5'h14, 32'h1);
      r0 = req_n;
      wr(5'h0C, 32'h03);
      idle(10);
      chk("R6 soc request", 32'(req_n - r0), 1);
      chk("R6 scope soc", 32'(last_scope), 0);
      wr(5'h0C, 0);

      // R7/R9 pre-timeout, threshold 256
      wr(5'h04, 32'd300); wr(5'h08, 32'h4755); wr(5'h14, 32'h1);
      wr(5'h0C, 32'h105);
      idle(20);
      chk("R7 above threshold", 32'(irq_o), 0);
      idle(40);
      chk("R7 below threshold", 32'(irq_o), 1);
      wr(5'h0C, 0);
      idle(10);
      chk("R7 level held", 32'(irq_o), 1);
      wr(5'h14, 32'h2);
      chk("R9 bit0 clear ignored", 32'(irq_o), 1);
      rd(5'h10, d); chk("R9 status kept", d, 32'h4);
      wr(5'h14, 32'h1);
      chk("R9 irq cleared", 32'(irq_o), 0);
      rd(5'h10, d); chk("R9 status cleared", d, 0);

      // R7 interrupt disabled
      wr(5'h04, 32'd300); wr(5'h08, 32'h4755);
      wr(5'h0C, 32'h101);
      idle(60);
      chk("R7 irq disabled", 32'(irq_o), 0);
      wr(5'h0C, 0);

      $display("  test done: total=%0d bad=%0d", nchk, nbad);
      $finish;
   end
endmodule